// File: doc/BRIEF.md
# Telemetry Scheduler with Power Averaging

This block drives a single multiplexed 12-bit converter through a fixed sequence of five telemetry channels: input voltage, input current, output voltage, auxiliary voltage and temperature. A new sequence starts at a fixed interval of clock cycles, which stands for the 1 ms scan period. Each conversion is a request/done exchange with the converter. The latest reading of each channel is held on an output.

When the current sample arrives, the block multiplies it by the voltage sample from the same scan and keeps the upper half of the product as the instantaneous input power. It also tracks the largest power value seen since reset or since the last clear. It averages input voltage, input current, input power and output voltage over a window of 2^k scans, where k can be set from 0 to 12. Power is averaged sample by sample, so the result is the mean of the products and not the product of the means.

Four readings are compared against programmable warning limits: input voltage, input current, input power and temperature. An exceeded limit sets a sticky status bit. The alert output is high while any status bit that is not masked is set. Status is cleared only by an explicit clear command.

Top module: `tlm_sched`

## Requirements
- R1: Each scan issues exactly one single-cycle converter request per channel, in the order 0 input voltage, 1 input current, 2 output voltage, 3 auxiliary, 4 temperature (the code appears on `adc_ch`). The next request comes only after `adc_done` for the previous one.
- R2: Scans begin exactly every `ROUND_CLKS` clock cycles. The first channel-0 requests of consecutive scans are `ROUND_CLKS` cycles apart.
- R3: After a conversion completes, the matching output among `vin`, `iin`, `vout`, `vaux` and `temp` holds the returned code until that channel is converted again.
- R4: `pin_now` equals bits [23:12] of the 24-bit product of the current scan's input voltage and input current codes.
- R5: Averages cover 2^`avg_log2` scans, with codes above 12 treated as 12. Each average register is loaded with floor(sum/length) once per completed window and holds its value in between. Before the first window completes it reads 0.
- R6: `avg_pin` is the mean of the per-scan `pin_now` values in the window, not the product of the voltage and current averages.
- R7: `pin_peak` is the largest `pin_now` value since reset or since the last `peak_clr`. A `peak_clr` pulse sets it to 0.
- R8: `warn_status` bit 0 is set when `vin` > `thr_vin`, bit 1 when `iin` > `thr_iin`, bit 2 when `pin_now` > `thr_pin`, and bit 3 when `temp` > `thr_temp`. Each bit sets one cycle after the comparison becomes true and stays set after the value returns below its limit.
- R9: `alert` is 1 exactly when some `warn_status` bit is set whose `warn_mask` bit is 0. A masked source still sets its status bit.
- R10: A `warn_clr` pulse clears all status bits. A bit whose comparison is still true sets again on the following cycle.
- R11: After reset, `adc_req`, `alert`, `warn_status`, `pin_peak` and all averages are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_req | output | 1 | Single-cycle conversion request |
| adc_ch | output | 3 | Channel code of the request |
| adc_done | input | 1 | Conversion complete, data valid |
| adc_data | input | 12 | Converted code |
| avg_log2 | input | 4 | Averaging window exponent (above 12 treated as 12) |
| thr_vin | input | 12 | Input voltage warning limit |
| thr_iin | input | 12 | Input current warning limit |
| thr_pin | input | 12 | Input power warning limit |
| thr_temp | input | 12 | Temperature warning limit |
| warn_mask | input | 4 | Per-source alert mask, 1 = suppressed |
| warn_clr | input | 1 | Clear all status bits |
| peak_clr | input | 1 | Clear the peak power register |
| vin | output | 12 | Latest input voltage code |
| iin | output | 12 | Latest input current code |
| vout | output | 12 | Latest output voltage code |
| vaux | output | 12 | Latest auxiliary code |
| temp | output | 12 | Latest temperature code |
| pin_now | output | 12 | Instantaneous input power |
| pin_peak | output | 12 | Peak input power |
| avg_vin | output | 12 | Windowed mean of input voltage |
| avg_iin | output | 12 | Windowed mean of input current |
| avg_pin | output | 12 | Windowed mean of input power |
| avg_vout | output | 12 | Windowed mean of output voltage |
| warn_status | output | 4 | Sticky warning bits |
| alert | output | 1 | Unmasked warning present |

## Verification
The averaging path is swept over window lengths of 1, 2, 4 and 8 scans. The voltage and current ramps move in unrelated directions, so the mean of products differs from the product of means, and every scan shows whether the average is held or reloaded at a window boundary. An oversized window code shows that the clamp keeps the averages at zero over a short run. The warning path goes through four sequences: a single source crossing its limit, the limit being lifted again (stickiness), masking, and clearing while the cause persists, which must re-set the bit one cycle later. The converter model checks channel order and scan spacing on every request.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
   localparam int NUM_CH = 5;
   localparam int CHW    = 3;
   localparam int NUM_WARN = 4;

   typedef enum logic [CHW-1:0] {
      CH_VIN  = 3'd0,
      CH_IIN  = 3'd1,
      CH_VOUT = 3'd2,
      CH_VAUX = 3'd3,
      CH_TEMP = 3'd4
   } tlm_ch_e;

   localparam int WB_VIN  = 0;
   localparam int WB_IIN  = 1;
   localparam int WB_PIN  = 2;
   localparam int WB_TEMP = 3;
endpackage

// File: rtl/tlm_seq.sv
module tlm_seq
   import tlm_pkg::*;
#(
   parameter int DW         = 12,
   parameter int ROUND_CLKS = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          adc_req,
   output logic [CHW-1:0] adc_ch,
   input  logic          adc_done,
   input  logic [DW-1:0] adc_data,
   output logic          smp_vld,
   output tlm_ch_e       smp_ch,
   output logic [DW-1:0] smp_data,
   output logic          round_end
);
   localparam int TW = $clog2(ROUND_CLKS);

   if (ROUND_CLKS < 2 * NUM_CH) begin : g_bad_round
      $error("ROUND_CLKS too short for one scan");
   end

   typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

   st_e           st;
   tlm_ch_e       ch;
   logic [TW-1:0] tcnt;
   logic          tick;

   assign tick    = (tcnt == TW'(ROUND_CLKS - 1));
   assign adc_req = (st == S_REQ);
   assign adc_ch  = ch;

   always_ff @(posedge clk) begin
      if (!rst_n) tcnt <= '0;
      else        tcnt <= tick ? '0 : tcnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         ch        <= CH_VIN;
         smp_vld   <= 1'b0;
         smp_ch    <= CH_VIN;
         smp_data  <= '0;
         round_end <= 1'b0;
      end else begin
         smp_vld   <= 1'b0;
         round_end <= 1'b0;
         case (st)
            S_IDLE: if (tick) begin
               ch <= CH_VIN;
               st <= S_REQ;
            end
            S_REQ: st <= S_WAIT;
            S_WAIT: if (adc_done) begin
               smp_vld  <= 1'b1;
               smp_ch   <= ch;
               smp_data <= adc_data;
               if (ch == CH_TEMP) begin
                  round_end <= 1'b1;
                  st        <= S_IDLE;
               end else begin
                  ch <= tlm_ch_e'(ch + 3'd1);
                  st <= S_REQ;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R1: a request lasts one cycle
   a_r1_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req |=> !adc_req);
   // R1: requested channel code is always a valid one
   a_r1_ch_range: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req |-> (adc_ch < CHW'(NUM_CH)));
   // R1: a sample is only produced from a completed conversion
   a_r1_vld_from_done: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |-> $past(adc_done));
endmodule

// File: rtl/tlm_avg.sv
module tlm_avg #(
   parameter int DW       = 12,
   parameter int LOG2_MAX = 12,
   parameter int LW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] din,
   input  logic [LW-1:0] win_log2,
   output logic [DW-1:0] avg
);
   localparam int SW = DW + LOG2_MAX;
   localparam int CW = LOG2_MAX + 1;

   if ((1 << LW) <= LOG2_MAX) begin : g_bad_lw
      $error("LW cannot encode LOG2_MAX");
   end

   logic [SW-1:0] acc, sum;
   logic [CW-1:0] cnt, cnt_nx, len;

   assign len    = CW'(1) << win_log2;
   assign sum    = acc + SW'(din);
   assign cnt_nx = cnt + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
         cnt <= '0;
         avg <= '0;
      end else if (go) begin
         if (cnt_nx >= len) begin
            avg <= DW'(sum >> win_log2);
            acc <= '0;
            cnt <= '0;
         end else begin
            acc <= sum;
            cnt <= cnt_nx;
         end
      end
   end

   // R5: the window code reaching here is already clamped
   a_r5_win_range: assert property (@(posedge clk) disable iff (!rst_n)
      win_log2 <= LW'(LOG2_MAX));
   // R5: average only moves on a sample
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> $stable(avg));
endmodule

// File: rtl/tlm_warn.sv
module tlm_warn #(
   parameter int DW = 12,
   parameter int NW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NW-1:0][DW-1:0] val,
   input  logic [NW-1:0][DW-1:0] thr,
   input  logic [NW-1:0]        mask,
   input  logic                 clr,
   output logic [NW-1:0]        status,
   output logic                 alert
);
   logic [NW-1:0] over;

   for (genvar i = 0; i < NW; i++) begin : g_cmp
      assign over[i] = (val[i] > thr[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   status <= '0;
      else if (clr) status <= '0;
      else          status <= status | over;
   end

   assign alert = |(status & ~mask);

   // R8: without a clear no status bit ever drops
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/tlm_sched.sv
module tlm_sched
   import tlm_pkg::*;
#(
   parameter int DW         = 12,
   parameter int LOG2_MAX   = 12,
   parameter int ROUND_CLKS = 1000,
   parameter int LW         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          adc_req,
   output logic [2:0]    adc_ch,
   input  logic          adc_done,
   input  logic [DW-1:0] adc_data,
   input  logic [LW-1:0] avg_log2,
   input  logic [DW-1:0] thr_vin,
   input  logic [DW-1:0] thr_iin,
   input  logic [DW-1:0] thr_pin,
   input  logic [DW-1:0] thr_temp,
   input  logic [3:0]    warn_mask,
   input  logic          warn_clr,
   input  logic          peak_clr,
   output logic [DW-1:0] vin,
   output logic [DW-1:0] iin,
   output logic [DW-1:0] vout,
   output logic [DW-1:0] vaux,
   output logic [DW-1:0] temp,
   output logic [DW-1:0] pin_now,
   output logic [DW-1:0] pin_peak,
   output logic [DW-1:0] avg_vin,
   output logic [DW-1:0] avg_iin,
   output logic [DW-1:0] avg_pin,
   output logic [DW-1:0] avg_vout,
   output logic [3:0]    warn_status,
   output logic          alert
);
   localparam int PW   = 2 * DW;
   localparam int NAVG = 4;

   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if (CHW != 3 || NUM_WARN != 4) begin : g_bad_pkg
      $error("package widths do not match the port list");
   end

   logic          smp_vld, round_end;
   tlm_ch_e       smp_ch;
   logic [DW-1:0] smp_data;
   logic [PW-1:0] prod;
   logic [DW-1:0] pin_new;
   logic [LW-1:0] win;

   tlm_seq #(.DW(DW), .ROUND_CLKS(ROUND_CLKS)) i_seq (
      .clk(clk), .rst_n(rst_n),
      .adc_req(adc_req), .adc_ch(adc_ch),
      .adc_done(adc_done), .adc_data(adc_data),
      .smp_vld(smp_vld), .smp_ch(smp_ch), .smp_data(smp_data),
      .round_end(round_end)
   );

   // product of this scan's voltage with the arriving current sample
   assign prod    = PW'(vin) * PW'(smp_data);
   assign pin_new = DW'(prod >> DW);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vin <= '0; iin <= '0; vout <= '0; vaux <= '0; temp <= '0;
         pin_now <= '0;
      end else if (smp_vld) begin
         case (smp_ch)
            CH_VIN:  vin  <= smp_data;
            CH_IIN: begin
               iin     <= smp_data;
               pin_now <= pin_new;
            end
            CH_VOUT: vout <= smp_data;
            CH_VAUX: vaux <= smp_data;
            CH_TEMP: temp <= smp_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || peak_clr)
         pin_peak <= '0;
      else if (smp_vld && smp_ch == CH_IIN && pin_new > pin_peak)
         pin_peak <= pin_new;
   end

   assign win = (avg_log2 > LW'(LOG2_MAX)) ? LW'(LOG2_MAX) : avg_log2;

   logic [NAVG-1:0][DW-1:0] av_in, av_out;
   assign av_in = {vout, pin_now, iin, vin};

   for (genvar i = 0; i < NAVG; i++) begin : g_avg
      tlm_avg #(.DW(DW), .LOG2_MAX(LOG2_MAX), .LW(LW)) i_avg (
         .clk(clk), .rst_n(rst_n), .go(round_end),
         .din(av_in[i]), .win_log2(win), .avg(av_out[i])
      );
   end

   assign avg_vin  = av_out[0];
   assign avg_iin  = av_out[1];
   assign avg_pin  = av_out[2];
   assign avg_vout = av_out[3];

   logic [NUM_WARN-1:0][DW-1:0] w_val, w_thr;
   always_comb begin
      w_val[WB_VIN]  = vin;     w_thr[WB_VIN]  = thr_vin;
      w_val[WB_IIN]  = iin;     w_thr[WB_IIN]  = thr_iin;
      w_val[WB_PIN]  = pin_now; w_thr[WB_PIN]  = thr_pin;
      w_val[WB_TEMP] = temp;    w_thr[WB_TEMP] = thr_temp;
   end

   tlm_warn #(.DW(DW), .NW(NUM_WARN)) i_warn (
      .clk(clk), .rst_n(rst_n), .val(w_val), .thr(w_thr),
      .mask(warn_mask), .clr(warn_clr),
      .status(warn_status), .alert(alert)
   );

   // R7: peak never falls unless cleared
   a_r7_peak_mono: assert property (@(posedge clk) disable iff (!rst_n)
      !peak_clr |=> (pin_peak >= $past(pin_peak)));
   // R9: an alert always has a status bit behind it
   a_r9_alert_src: assert property (@(posedge clk) disable iff (!rst_n)
      alert |-> (warn_status != '0));
   // R4: power only changes on a current sample
   a_r4_pin_update: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_vld && smp_ch == CH_IIN) |=> $stable(pin_now));
endmodule

// File: tb/test_tlm_sched.sv
module test_tlm_sched;
   localparam int DW  = 12;
   localparam int RC  = 64;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adc_req, adc_done = 1'b0;
   logic [2:0] adc_ch;
   logic [DW-1:0] adc_data = '0;
   logic [3:0] avg_log2 = '0;
   logic [DW-1:0] thr_vin = '1, thr_iin = '1, thr_pin = '1, thr_temp = '1;
   logic [3:0] warn_mask = '0;
   logic warn_clr = 1'b0, peak_clr = 1'b0;
   logic [DW-1:0] vin, iin, vout, vaux, temp, pin_now, pin_peak;
   logic [DW-1:0] avg_vin, avg_iin, avg_pin, avg_vout;
   logic [3:0] warn_status;
   logic alert;

   int ncheck = 0, nfail = 0;
   int rnd = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   tlm_sched #(.DW(DW), .LOG2_MAX(12), .ROUND_CLKS(RC), .LW(4)) i_tlm_sched (
      .clk(clk), .rst_n(rst_n), .adc_req(adc_req), .adc_ch(adc_ch),
      .adc_done(adc_done), .adc_data(adc_data), .avg_log2(avg_log2),
      .thr_vin(thr_vin), .thr_iin(thr_iin), .thr_pin(thr_pin), .thr_temp(thr_temp),
      .warn_mask(warn_mask), .warn_clr(warn_clr), .peak_clr(peak_clr),
      .vin(vin), .iin(iin), .vout(vout), .vaux(vaux), .temp(temp),
      .pin_now(pin_now), .pin_peak(pin_peak),
      .avg_vin(avg_vin), .avg_iin(avg_iin), .avg_pin(avg_pin), .avg_vout(avg_vout),
      .warn_status(warn_status), .alert(alert)
   );

   function automatic int vin_of(int k);  return (k * 523 + 1200) % 4096; endfunction
   function automatic int iin_of(int k);  return (k * 1777 + 300) % 4096; endfunction
   function automatic int vout_of(int k); return (k * 97 + 2000) % 4096;  endfunction
   function automatic int aux_of(int k);  return (k * 61 + 7) % 4096;     endfunction
   function automatic int temp_of(int k); return (k * 29 + 150) % 4096;   endfunction
   function automatic int pin_of(int k);  return (vin_of(k) * iin_of(k)) >> 12; endfunction

   function automatic int sel_of(int s, int k);
      case (s)
         0: return vin_of(k);
         1: return iin_of(k);
         2: return pin_of(k);
         default: return vout_of(k);
      endcase
   endfunction

   function automatic int exp_avg(int s, int r, int l);
      int n = 1 << l;
      int c = r / n;
      int acc = 0;
      if (c == 0) return 0;
      for (int k = (c - 1) * n + 1; k <= c * n; k++) acc += sel_of(s, k);
      return acc / n;
   endfunction

   function automatic int data_of(int ch, int k);
      case (ch)
         0: return vin_of(k);
         1: return iin_of(k);
         2: return vout_of(k);
         3: return aux_of(k);
         default: return temp_of(k);
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      ncheck++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // converter model: fixed latency, scripted codes, order and spacing checks (R1, R2)
   initial begin
      bit busy = 0;
      int lat = 0, pch = 0, exp_ch = 0, last0 = -1;
      forever begin
         @(negedge clk);
         cyc++;
         adc_done = 1'b0;
         if (!rst_n) begin
            busy = 0; rnd = 0; exp_ch = 0; last0 = -1;
         end else begin
            if (busy) begin
               if (lat == 0) begin
                  adc_done = 1'b1;
                  adc_data = DW'(data_of(pch, rnd + 1));
                  busy = 0;
                  if (pch == 4) rnd++;
               end else lat--;
            end
            if (adc_req) begin
               check("R1 channel order", int'(adc_ch), exp_ch);
               check("R1 no request while busy", int'(busy), 0);
               if (adc_ch == 3'd0) begin
                  if (last0 >= 0) check("R2 scan spacing", cyc - last0, RC);
                  last0 = cyc;
               end
               exp_ch = (exp_ch + 1) % 5;
               busy = 1; lat = LAT; pch = int'(adc_ch);
            end
         end
      end
   end

   task automatic do_reset(int l);
      @(negedge clk);
      rst_n = 1'b0;
      avg_log2 = 4'(l);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_round(int k);
      while (rnd < k) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", ncheck, nfail);
      $finish;
   end

   initial begin
      int pk;
      do_reset(0);
      @(negedge clk);
      // R11 reset state
      check("R11 adc_req", int'(adc_req), 0);
      check("R11 alert", int'(alert), 0);
      check("R11 status", int'(warn_status), 0);
      check("R11 peak", int'(pin_peak), 0);
      check("R11 avg_pin", int'(avg_pin), 0);

      // window sweep over lengths 1,2,4,8 (R3..R7)
      for (int l = 0; l < 4; l++) begin
         do_reset(l);
         pk = 0;
         for (int r = 1; r <= 2 * (1 << l) + 1; r++) begin
            wait_round(r);
            if (pin_of(r) > pk) pk = pin_of(r);
            check("R3 vin", int'(vin), vin_of(r));
            check("R3 iin", int'(iin), iin_of(r));
            check("R3 vout", int'(vout), vout_of(r));
            check("R3 vaux", int'(vaux), aux_of(r));
            check("R3 temp", int'(temp), temp_of(r));
            check("R4 pin_now", int'(pin_now), pin_of(r));
            check("R5 avg_vin", int'(avg_vin), exp_avg(0, r, l));
            check("R5 avg_iin", int'(avg_iin), exp_avg(1, r, l));
            check("R5 avg_vout", int'(avg_vout), exp_avg(3, r, l));
            check("R6 avg_pin", int'(avg_pin), exp_avg(2, r, l));
            check("R7 peak", int'(pin_peak), pk);
         end
      end

      // peak clear, then next scan reloads (R7); state is round 17 of l=3
      @(negedge clk); peak_clr = 1'b1;
      @(negedge clk); peak_clr = 1'b0;
      check("R7 peak cleared", int'(pin_peak), 0);
      check("R7 pin_now kept", int'(pin_now), pin_of(17));
      wait_round(18);
      check("R7 peak after clear", int'(pin_peak), pin_of(18));

      // oversized window code clamps to 4096 scans (R5)
      do_reset(15);
      wait_round(3);
      check("R5 clamp avg_vin", int'(avg_vin), 0);
      check("R5 clamp avg_pin", int'(avg_pin), 0);

      // warnings (R8..R10)
      do_reset(0);
      wait_round(1);
      check("R8 no warning", int'(warn_status), 0);
      check("R9 no alert", int'(alert), 0);
      thr_vin = DW'(vin_of(2) - 1);
      wait_round(2);
      check("R8 vin over", int'(warn_status), 1);
      check("R9 alert on", int'(alert), 1);
      thr_vin = '1;
      warn_mask = 4'b0001;
      @(negedge clk);
      check("R9 masked alert", int'(alert), 0);
      check("R8 sticky masked", int'(warn_status), 1);
      warn_mask = 4'b0000;
      @(negedge clk);
      check("R9 unmasked alert", int'(alert), 1);
      warn_clr = 1'b1;
      @(negedge clk); warn_clr = 1'b0;
      check("R10 cleared", int'(warn_status), 0);
      check("R10 alert released", int'(alert), 0);
      thr_iin = '0; thr_pin = '0; thr_temp = '0;
      @(negedge clk);
      check("R8 iin pin temp over", int'(warn_status), 14);
      warn_clr = 1'b1;
      @(negedge clk); warn_clr = 1'b0;
      check("R10 clear while over", int'(warn_status), 0);
      @(negedge clk);
      check("R10 re-set next cycle", int'(warn_status), 14);
      warn_mask = 4'b1110;
      @(negedge clk);
      check("R9 all masked", int'(alert), 0);

      $display("  CHECKS %0d ERRORS %0d", ncheck, nfail);
      $finish;
   end
endmodule